// File: doc/BRIEF.md
# MLT-3 Receive Symbol Deserializer

This block is the digital receive datapath of a 100 Mb/s copper physical layer. It runs on the recovered bit clock. On each cycle it takes two sliced comparator flags: one says the line level is above the positive threshold, the other says it is below the negative threshold. It rebuilds the NRZI stream from the magnitude of the level, then turns NRZI into NRZ by detecting changes between consecutive bits. The NRZ bits are gathered into groups of `SYM_W`. Each complete group is latched into a hold register. One bit cycle later it is copied to the symbol output, and a one-cycle strobe acts as the divide-by-`SYM_W` receive clock enable.

A loopback input replaces the line with the transmit serial NRZI stream. While loopback is on, the signal-detect output is forced high. Otherwise that output follows the analog detector flag. When there is no signal and loopback is off, the groups are blanked to zero. Group boundaries are fixed by a counter that starts at reset. Code-group alignment is left to the next layer.

Top module: `mlt3_symbol_rx`

## Requirements
- R1: In normal mode the NRZI bit is 1 when `cmp_pos` (level +1) or `cmp_neg` (level -1) is high, and 0 when both are low (level 0).
- R2: The NRZ bit is 1 when the current NRZI bit differs from the NRZI bit of the previous cycle, and 0 when it is the same.
- R3: Within a symbol, the first NRZ bit of the group appears in bit `SYM_W-1` of `rx_sym` and the last appears in bit 0.
- R4: `rx_sym` changes only in the cycle that follows a rising edge at which `rx_stb` rises. `rx_stb` is high for exactly one cycle per group. A group whose last bit is sampled at edge t is driven on `rx_sym` from edge t+1, with `rx_stb` high for that one cycle.
- R5: The first group consists of the bits sampled at the first `SYM_W` rising edges after reset is released. Later groups follow back to back with no gaps.
- R6: While `lpbk_en` is 1, `lpbk_bit` is taken as the NRZI bit and the comparator inputs have no effect on `rx_sym`.
- R7: `sd_out` is registered. After each rising edge it equals 1 if `lpbk_en` was 1 at that edge, and otherwise it equals the `sd_in` value sampled at that edge.
- R8: A group whose last bit is sampled while `sd_in` is 0 and `lpbk_en` is 0 is presented as all zeros.
- R9: During reset `rx_sym` is 0, `rx_stb` is 0 and `sd_out` is 0. The previous-NRZI register resets to 0, so the first NRZ bit after reset compares against 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock (125 MHz in the system) |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_pos | input | 1 | Level comparator: line above positive threshold |
| cmp_neg | input | 1 | Level comparator: line below negative threshold |
| lpbk_en | input | 1 | Loopback select: 1 routes transmit stream into receive path |
| lpbk_bit | input | 1 | Transmit serial NRZI bit used in loopback |
| sd_in | input | 1 | Analog signal-detect flag |
| rx_sym | output | SYM_W | Latched receive symbol, first bit in MSB |
| rx_stb | output | 1 | One-cycle receive clock enable, marks a new symbol |
| sd_out | output | 1 | Signal detect, forced high in loopback |

## Verification
The bench builds the block with the default `SYM_W` of 5, so every fifth bit closes a group. Switching modes at group boundaries then exercises blanking and loopback on whole symbols. A bench-side three-level line model cycles through 0, +1, 0, -1. This drives both comparators and lets the NRZI state carry across mode switches. With a five-bit group, the all-ones, all-zeros, single-bit-at-either-end and alternating patterns each fit in one symbol, which checks the bit order directly.

// File: rtl/mlt3_symbol_rx.sv
module mlt3_symbol_rx #(
  parameter int SYM_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_pos,
  input  logic             cmp_neg,
  input  logic             lpbk_en,
  input  logic             lpbk_bit,
  input  logic             sd_in,
  output logic [SYM_W-1:0] rx_sym,
  output logic             rx_stb,
  output logic             sd_out
);

  localparam int CW = (SYM_W > 2) ? $clog2(SYM_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(SYM_W - 1);

  logic             nrzi_now, nrzi_prev, nrz;
  logic [SYM_W-2:0] sh;
  logic [SYM_W-1:0] hold;
  logic [CW-1:0]    cnt;
  logic             vld;
  logic             grp_end;
  logic             live;

  assign nrzi_now = lpbk_en ? lpbk_bit : (cmp_pos | cmp_neg);
  assign nrz      = nrzi_now ^ nrzi_prev;
  assign grp_end  = (cnt == LAST);
  assign live     = sd_in | lpbk_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nrzi_prev <= 1'b0;
      sh        <= '0;
      hold      <= '0;
      cnt       <= '0;
      vld       <= 1'b0;
      rx_sym    <= '0;
      rx_stb    <= 1'b0;
      sd_out    <= 1'b0;
    end else begin
      nrzi_prev <= nrzi_now;
      sh        <= {sh[SYM_W-3:0], nrz};
      cnt       <= grp_end ? '0 : cnt + 1'b1;
      sd_out    <= live;
      if (grp_end) begin
        hold <= live ? {sh, nrz} : '0;
        vld  <= 1'b1;
      end
      rx_stb <= vld && (cnt == '0);
      if (vld && (cnt == '0))
        rx_sym <= hold;
    end
  end

  a_r1_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    (!lpbk_en && !cmp_pos && !cmp_neg) |=> !nrzi_prev);

  a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stb |=> !rx_stb);

  a_r4_sym_held: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_stb |-> $stable(rx_sym));

  a_r5_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  a_r7_sd_forced: assert property (@(posedge clk) disable iff (!rst_n)
    lpbk_en |=> sd_out);

  a_r8_blank_group: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_end && !sd_in && !lpbk_en) |=> (hold == '0));

endmodule

// File: tb/mlt3_symbol_rx_tb_top.sv
module mlt3_symbol_rx_tb_top;
  localparam int W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp_pos = 1'b0, cmp_neg = 1'b0, lpbk_en = 1'b0, lpbk_bit = 1'b0, sd_in = 1'b0;
  logic [W-1:0] rx_sym;
  logic rx_stb, sd_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [W-1:0] exp_q[$];
  logic last_nrzi = 1'b0;
  int   mlt_st = 0;
  int   noise = 7;

  always #10 clk = ~clk;

  mlt3_symbol_rx #(.SYM_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmp_pos(cmp_pos), .cmp_neg(cmp_neg),
    .lpbk_en(lpbk_en), .lpbk_bit(lpbk_bit), .sd_in(sd_in),
    .rx_sym(rx_sym), .rx_stb(rx_stb), .sd_out(sd_out));

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Driver: drives one group of W bits starting at the current negedge.
  task automatic send_group(input logic [W-1:0] sym, input bit lp, input bit sd);
    exp_q.push_back((lp || sd) ? sym : '0);
    for (int i = W - 1; i >= 0; i--) begin
      logic tgt;
      tgt = last_nrzi ^ sym[i];
      lpbk_en = lp;
      sd_in   = sd;
      noise   = (noise * 5 + 3) % 16;
      if (lp) begin
        lpbk_bit = tgt;
        mlt_st   = (mlt_st + noise[0]) % 4;
      end else begin
        lpbk_bit = noise[1];
        if ((mlt_st % 2) != int'(tgt)) mlt_st = (mlt_st + 1) % 4;
      end
      cmp_pos = (mlt_st == 1);
      cmp_neg = (mlt_st == 3);
      last_nrzi = tgt;
      @(negedge clk);
      chk(sd_out == (lp || sd), "R7 sd_out", {4'b0, sd_out}, {4'b0, (lp || sd)});
    end
  endtask

  // Monitor: pops one expected symbol per strobe.
  always @(negedge clk) begin
    if (rst_n && rx_stb) begin
      if (exp_q.size() == 0)
        chk(1'b0, "R4 unexpected strobe", rx_sym, '0);
      else begin
        logic [W-1:0] e;
        e = exp_q.pop_front();
        chk(rx_sym == e, "R1 R2 R3 R6 R8 symbol", rx_sym, e);
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(rx_sym == '0, "R9 rx_sym in reset", rx_sym, '0);
    chk(rx_stb == 1'b0, "R9 rx_stb in reset", {4'b0, rx_stb}, '0);
    chk(sd_out == 1'b0, "R9 sd_out in reset", {4'b0, sd_out}, '0);
    rst_n = 1'b1;
    // R5: first group begins at the first edge after release; R9 prev NRZI = 0
    send_group(5'b10000, 0, 1);   // R3 first bit lands in MSB
    send_group(5'b00001, 0, 1);   // R3 last bit lands in LSB
    send_group(5'b11111, 0, 1);   // R1 R2 both comparator polarities
    send_group(5'b00000, 0, 1);
    send_group(5'b10101, 0, 1);
    send_group(5'b01101, 0, 0);   // R8 blanked
    send_group(5'b11011, 0, 0);   // R8 blanked
    send_group(5'b11001, 1, 0);   // R6 loopback, R7 forced detect
    send_group(5'b00110, 1, 1);   // R6 comparators carry noise
    send_group(5'b11111, 1, 0);
    send_group(5'b01010, 0, 1);   // back to line, NRZI continues
    send_group(5'b10011, 0, 1);
    for (int k = 0; k < 20; k++)
      send_group(W'((k * 7 + 3) % 32), k % 3 == 0, k % 4 != 1);
    send_group(5'b00000, 0, 1);   // flush
    repeat (3) @(negedge clk);
    chk(exp_q.size() <= 1, "R4 R5 strobe per group", W'(exp_q.size()), '0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule